// File: doc/BRIEF.md
# Clocked One-Shot Pulse Generator

This block is a monostable pulse source timed entirely by the system clock. It rests in a single stable state, with the true output low and the complementary output high. When the trigger input goes from low to high, the block enters its active state for a programmed number of clock cycles. It then falls back to rest without any further input. The trigger is treated as asynchronous. It passes through a synchronizer chain and a registered rising-edge detector, so a trigger held at one level never starts a pulse.

A run-time mode bit sets what happens to trigger edges that arrive during an active pulse. In single-shot mode they are dropped. In restart mode each one starts the full interval again from that edge, so the pulse is stretched. A one-cycle completion strobe marks the end of every pulse.

Top module: `oneshot_pulse`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pulse_o` is 0, `pulse_n_o` is 1 and `done_o` is 0. The edge history resets to the high level, so a trigger that is already high when reset is released starts no pulse.
- R2: A pulse starts only on a low-to-high change of `trig_i`. If `trig_i` is set before rising edge E0 and was low at the edge before E0, `pulse_o` goes high after edge E3. A trigger held high, however long, produces exactly one pulse.
- R3: When `retrig_i` is 0 (single-shot mode), a trigger edge that reaches the counter while a pulse is active is ignored, and the running interval finishes unchanged.
- R4: `len_i` is an unsigned cycle count N. The pulse stays high for exactly N cycles, and N = 0 gives one cycle.
- R5: When `retrig_i` is 1 (restart mode), a trigger edge that reaches the counter during a pulse reloads the full count from that edge, which lengthens the pulse.
- R6: `len_i` and `retrig_i` are used only on the clock edge that starts or restarts a pulse. Changing them in the middle of a pulse does not alter the interval already running.
- R7: `pulse_n_o` is always the inverse of `pulse_o`.
- R8: `done_o` is high for exactly one cycle, which is the first cycle after `pulse_o` falls, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Asynchronous trigger |
| retrig_i | input | 1 | Mode: 0 = single-shot, 1 = restart |
| len_i | input | CNT_W (16) | Pulse length in cycles (0 treated as 1) |
| pulse_o | output | 1 | True output, high while active |
| pulse_n_o | output | 1 | Complementary output |
| done_o | output | 1 | One-cycle strobe at pulse end |

## Verification
Suppose the trigger is set up before rising edge E0. Two synchronizer edges and one edge-detector edge follow, so `pulse_o` first reads high after E3. It stays high for N edges, and `done_o` is high for the one cycle after the last active cycle. The bench keeps a behavioural model built from a short history of trigger samples. That model marks a start three edges after the sampled rise, takes length and mode at that start edge, and counts the interval down. Every output is compared against the model at each falling clock edge, halfway between two updates, so each result is checked in the exact cycle it is due.

// File: rtl/os_pkg.sv
package os_pkg;
   typedef enum logic {
      OS_MODE_SINGLE  = 1'b0,
      OS_MODE_RESTART = 1'b1
   } os_mode_e;

   localparam int OS_MIN_SYNC = 2;
   localparam int OS_MIN_CNT  = 2;
endpackage

// File: rtl/os_trig_edge.sv
module os_trig_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_i,
   output logic stb_o
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < os_pkg::OS_MIN_SYNC) begin : g_bad
         $error("os_trig_edge: STAGES below minimum");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              hist_q;
   logic              stb_q;

   // Chain and history reset high: a level already present at release is not an edge.
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[i] <= 1'b1;
               else     chain_q[i] <= trig_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[i] <= 1'b1;
               else     chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_q <= 1'b1;
         stb_q  <= 1'b0;
      end else begin
         hist_q <= chain_q[LAST];
         stb_q  <= chain_q[LAST] & ~hist_q;
      end
   end

   assign stb_o = stb_q;
endmodule

// File: rtl/os_interval.sv
module os_interval #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stb_i,
   input  logic             restart_en_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             active_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < os_pkg::OS_MIN_CNT) begin : g_bad
         $error("os_interval: CNT_W below minimum");
      end
   endgenerate

   logic [CNT_W-1:0] left_q;
   logic             active_q;
   logic             done_q;
   logic [CNT_W-1:0] len_eff;
   logic             load;

   always_comb begin
      len_eff = (len_i == '0) ? ONE : len_i;
      load    = stb_i && (!active_q || restart_en_i);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q   <= '0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            left_q   <= len_eff;
            active_q <= 1'b1;
         end else if (active_q) begin
            if (left_q == ONE) begin
               left_q   <= '0;
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end else begin
               left_q <= left_q - ONE;
            end
         end
      end
   end

   assign active_o = active_q;
   assign done_o   = done_q;
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             trig_i,
   input  logic             retrig_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             pulse_o,
   output logic             pulse_n_o,
   output logic             done_o
);
   import os_pkg::*;

   os_mode_e mode;
   logic     trig_stb;
   logic     active;
   logic     restart_en;

   assign mode       = os_mode_e'(retrig_i);
   assign restart_en = (mode == OS_MODE_RESTART);

   os_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .trig_i (trig_i),
      .stb_o  (trig_stb)
   );

   os_interval #(.CNT_W(CNT_W)) u_interval (
      .clk          (clk),
      .rst          (rst),
      .stb_i        (trig_stb),
      .restart_en_i (restart_en),
      .len_i        (len_i),
      .active_o     (active),
      .done_o       (done_o)
   );

   assign pulse_o   = active;
   assign pulse_n_o = ~active;
endmodule

// File: rtl/os_checker.sv
module os_checker (
   input logic clk,
   input logic rst,
   input logic trig_stb,
   input logic pulse_o,
   input logic pulse_n_o,
   input logic done_o
);
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (!pulse_o && pulse_n_o && !done_o)); // R1

   AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_o) |-> $past(trig_stb)); // R2

   AST_OUTPUTS_INVERSE: assert property (@(posedge clk) disable iff (rst)
      pulse_n_o != pulse_o); // R7

   AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      $fell(pulse_o) |-> done_o); // R8

   AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
      done_o |-> ($past(pulse_o) && !pulse_o)); // R8
endmodule

bind oneshot_pulse os_checker u_chk (
   .clk       (clk),
   .rst       (rst),
   .trig_stb  (trig_stb),
   .pulse_o   (pulse_o),
   .pulse_n_o (pulse_n_o),
   .done_o    (done_o)
);

// File: tb/oneshot_pulse_tb.sv
`timescale 1ns/1ps
module oneshot_pulse_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         trig = 1'b0;
   logic         retrig = 1'b0;
   logic [W-1:0] len = 16'd4;
   logic         pulse, pulse_n, done;

   int    n_checks = 0;
   int    n_fail   = 0;
   int    cycles   = 0;
   int    pulses_seen = 0;
   string cur_req  = "R1";

   always #2.5 clk = ~clk;

   oneshot_pulse u_dut (
      .clk(clk), .rst(rst), .trig_i(trig), .retrig_i(retrig),
      .len_i(len), .pulse_o(pulse), .pulse_n_o(pulse_n), .done_o(done)
   );

   // Behavioural reference: sample history, remaining count, done flag
   int samp_q[$] = '{1, 1, 1, 1, 1};
   int rem = 0;
   int exp_done = 0;

   always @(posedge clk) begin
      int s;
      bit start;
      s = rst ? 1 : int'(trig);
      samp_q.push_front(s);
      void'(samp_q.pop_back());
      start = (samp_q[3] == 1) && (samp_q[4] == 0);
      exp_done = 0;
      if (rst) begin
         rem = 0;
      end else if (start && (rem == 0 || retrig)) begin
         rem = (len == 0) ? 1 : int'(len);
      end else if (rem > 0) begin
         rem = rem - 1;
         if (rem == 0) exp_done = 1;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      check(cur_req, "pulse_o", int'(pulse), (rem > 0) ? 1 : 0);
      check("R7", "pulse_n_o", int'(pulse_n), (rem > 0) ? 0 : 1);
      check("R8", "done_o", int'(done), exp_done);
      if (done) pulses_seen++;
      if (cycles > 20000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic fire(input int hi, input int lo);
      @(negedge clk); trig = 1'b1;
      idle(hi);
      trig = 1'b0;
      idle(lo);
   endtask

   initial begin
      // R1: reset with trigger high, then release while still high
      trig = 1'b1;
      idle(4);
      check("R1", "pulse_o in reset", int'(pulse), 0);
      check("R1", "pulse_n_o in reset", int'(pulse_n), 1);
      rst = 1'b0;
      idle(10);
      check("R1", "no pulse after release with high trigger", pulses_seen, 0);
      trig = 1'b0;
      idle(5);

      // R2: long high level gives one pulse; edge latency fixed by model
      cur_req = "R2";
      len = 16'd4;
      pulses_seen = 0;
      fire(25, 10);
      check("R2", "pulse count for held trigger", pulses_seen, 1);

      // R3: single-shot mode ignores edges during the pulse
      cur_req = "R3";
      retrig = 1'b0;
      len = 16'd9;
      pulses_seen = 0;
      fire(1, 2);
      fire(1, 2);
      fire(1, 15);
      check("R3", "pulse count single-shot", pulses_seen, 1);

      // R4: zero and one-cycle lengths, and a long one
      cur_req = "R4";
      len = 16'd0;
      fire(1, 8);
      len = 16'd1;
      fire(2, 8);
      len = 16'd30;
      fire(1, 40);

      // R5: restart mode stretches the pulse
      cur_req = "R5";
      retrig = 1'b1;
      len = 16'd6;
      pulses_seen = 0;
      fire(1, 2);
      fire(1, 2);
      fire(1, 2);
      fire(1, 15);
      check("R5", "pulse count restart", pulses_seen, 1);

      // R6: length and mode changes mid-pulse do not alter the running interval
      cur_req = "R6";
      retrig = 1'b0;
      len = 16'd12;
      @(negedge clk); trig = 1'b1;
      idle(5);
      len = 16'd2;
      retrig = 1'b1;
      idle(3);
      trig = 1'b0;
      idle(20);

      // R3 edge landing on the last active cycle in single-shot mode
      cur_req = "R3";
      retrig = 1'b0;
      len = 16'd4;
      fire(1, 2);
      fire(1, 12);

      idle(4);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule